// File: doc/BRIEF.md
# Pre-Trigger Channel Sequencer

This block drives one converter channel from a set of eight pre-trigger lines. After a start event each enabled pre-trigger fires in one of three ways: straight from the start event (bypass), when a shared counter equals its own delay value (timed), or in a chain, right after the conversion started by its lower neighbour completes. A one-cycle trigger strobe goes with every accepted pre-trigger. The counter, the conversion itself and any register bus are outside the block. The block sees the counter value and a tick strobe, a start input, a conversion-complete input and simple write ports.

Only one conversion may be in flight. The block keeps a busy state that the trigger strobe sets and the conversion-complete input clears. A pre-trigger that comes up while the channel is busy is dropped and leaves a sticky error bit for that pre-trigger. When several pre-triggers ask in the same cycle, the lowest index wins and the others are logged as errors. A separate set of sticky channel flags records counter matches of enabled pre-triggers. Both flag sets are cleared by writing 0 to a bit.

Top module: `pretrig_seq`

## Requirements
- R1: After reset, pretrig, trig, busy, chan_flag and seq_err are all zero.
- R2: The control word holds three per-pre-trigger fields: bits [7:0] enable, bits [15:8] mode select (0 = bypass, 1 = timed) and bits [23:16] chaining. It is loaded when cfg_we is high.
- R3: A start event is a rising edge of start, or a one-cycle sw_start pulse, sampled at clock edge k. An enabled bypass pre-trigger is accepted at edge k+1, so its pretrig bit is high for the cycle that follows that edge.
- R4: After a start event, an enabled timed pre-trigger that is not chained asks for a conversion at the edge where cnt_tick is high and cnt equals its delay. It asks at most once per start event, and the pretrig bit is high for the following cycle.
- R5: For pre-trigger m > 0 with chaining set, the delay is ignored. The pre-trigger asks for a conversion at the edge where conv_done is sampled while the running conversion was started by pre-trigger m-1.
- R6: Every accepted pre-trigger comes with trig high for the same single cycle, and busy rises at that edge. busy falls only at an edge where conv_done was sampled and nothing was accepted.
- R7: A request that arrives while busy is high and conv_done is low is rejected and sets seq_err[m]. When several requests arrive together on a free channel, the lowest index is accepted and the others set their error bits. At most one pretrig bit is ever high.
- R8: seq_err bits are sticky. With err_we high, a 0 in err_wdata clears the bit and a 1 leaves it unchanged.
- R9: chan_flag[m] is set at every edge where cnt_tick is high, cnt equals delay m and pre-trigger m is enabled. With flag_we high, a 0 in flag_wdata clears the bit.
- R10: A disabled pre-trigger never raises its pretrig bit, its chan_flag bit or its seq_err bit, even when its delay matches the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the control word |
| cfg_wdata | input | 3*NPT | Control word: enable, mode select, chaining |
| dly_we | input | 1 | Load one delay value |
| dly_idx | input | clog2(NPT) | Pre-trigger whose delay is loaded |
| dly_wdata | input | DW | Delay value |
| cnt | input | DW | Shared counter value |
| cnt_tick | input | 1 | Counter advanced; compare cnt this cycle |
| start | input | 1 | Start trigger level; rising edge starts a sequence |
| sw_start | input | 1 | Software start pulse |
| conv_done | input | 1 | Running conversion finished |
| flag_we | input | 1 | Write-0-to-clear strobe for chan_flag |
| flag_wdata | input | NPT | Clear mask for chan_flag (0 clears) |
| err_we | input | 1 | Write-0-to-clear strobe for seq_err |
| err_wdata | input | NPT | Clear mask for seq_err (0 clears) |
| pretrig | output | NPT | Accepted pre-trigger, one cycle |
| trig | output | 1 | Trigger strobe to the converter |
| busy | output | 1 | Conversion in flight |
| chan_flag | output | NPT | Sticky counter-match flags |
| seq_err | output | NPT | Sticky sequence error flags |

## Verification
One stimulus sequence uses a mix of modes: pre-trigger 0 in bypass, 1 and 2 timed, and 3 chained behind 2 with a delay the counter also hits. Pre-trigger 4 is disabled and shares a delay with pre-trigger 1. A bypass shot and a timed shot show the start path apart from the counter path. The counter passing pre-trigger 3's delay without a shot shows that chaining overrides the delay, and the chained shot on conv_done shows the source tracking. A second start with a timed match while busy separates rejection from acceptance. A later run with two pre-triggers on the same delay checks the lowest-index rule and the once-per-start limit. The write-0 clears are then applied with masks that keep some bits, so a wrong clear polarity is visible.

// File: rtl/pretrig_seq.sv
module pretrig_seq #(
  parameter int NPT = 8,
  parameter int DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [3*NPT-1:0]         cfg_wdata,
  input  logic                     dly_we,
  input  logic [$clog2(NPT)-1:0]   dly_idx,
  input  logic [DW-1:0]            dly_wdata,
  input  logic [DW-1:0]            cnt,
  input  logic                     cnt_tick,
  input  logic                     start,
  input  logic                     sw_start,
  input  logic                     conv_done,
  input  logic                     flag_we,
  input  logic [NPT-1:0]           flag_wdata,
  input  logic                     err_we,
  input  logic [NPT-1:0]           err_wdata,
  output logic [NPT-1:0]           pretrig,
  output logic                     trig,
  output logic                     busy,
  output logic [NPT-1:0]           chan_flag,
  output logic [NPT-1:0]           seq_err
);
  localparam int IW = $clog2(NPT);

  logic [NPT-1:0] en_q, tos_q, bb_q, fired_q;
  logic [DW-1:0]  dly_q [NPT];
  logic           start_q, ev_q, armed_q;
  logic [IW-1:0]  src_q, src_d;

  logic [NPT-1:0] hit, chain, chn_req, dly_req, byp_req, req, grant, rej;
  logic           free;

  for (genvar m = 0; m < NPT; m++) begin : g_pt
    assign hit[m] = cnt_tick && (cnt == dly_q[m]);
    if (m == 0) begin : g_head
      assign chain[m]   = 1'b0;
      assign chn_req[m] = 1'b0;
    end else begin : g_link
      assign chain[m]   = bb_q[m];
      assign chn_req[m] = en_q[m] && bb_q[m] && conv_done && busy && (src_q == IW'(m - 1));
    end
  end

  assign dly_req = en_q & tos_q & ~chain & hit & ~fired_q & {NPT{armed_q}};
  assign byp_req = en_q & ~tos_q & {NPT{ev_q}};
  assign req     = dly_req | byp_req | chn_req;
  assign free    = ~busy | conv_done;
  assign grant   = free ? (req & (~req + NPT'(1))) : '0;
  assign rej     = req & ~grant;

  always_comb begin
    src_d = src_q;
    for (int m = 0; m < NPT; m++)
      if (grant[m]) src_d = IW'(m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      tos_q <= '0;
      bb_q  <= '0;
    end else if (cfg_we) begin
      en_q  <= cfg_wdata[NPT-1:0];
      tos_q <= cfg_wdata[2*NPT-1:NPT];
      bb_q  <= cfg_wdata[3*NPT-1:2*NPT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NPT; m++) dly_q[m] <= '0;
    end else if (dly_we) begin
      dly_q[dly_idx] <= dly_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      ev_q      <= 1'b0;
      armed_q   <= 1'b0;
      fired_q   <= '0;
      busy      <= 1'b0;
      src_q     <= '0;
      pretrig   <= '0;
      trig      <= 1'b0;
      chan_flag <= '0;
      seq_err   <= '0;
    end else begin
      start_q <= start;
      ev_q    <= (start & ~start_q) | sw_start;
      if (ev_q) begin
        armed_q <= 1'b1;
        fired_q <= '0;
      end else begin
        fired_q <= fired_q | dly_req;
      end
      busy      <= (|grant) | (busy & ~conv_done);
      src_q     <= src_d;
      pretrig   <= grant;
      trig      <= |grant;
      chan_flag <= (flag_we ? (chan_flag & flag_wdata) : chan_flag) | (hit & en_q);
      seq_err   <= (err_we ? (seq_err & err_wdata) : seq_err) | rej;
    end
  end
endmodule

// File: rtl/pretrig_seq_chk.sv
module pretrig_seq_chk #(
  parameter int NPT = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPT-1:0] en_q,
  input logic           conv_done,
  input logic           err_we,
  input logic           flag_we,
  input logic [NPT-1:0] pretrig,
  input logic           trig,
  input logic           busy,
  input logic [NPT-1:0] chan_flag,
  input logic [NPT-1:0] seq_err
);
  a_r7_one_pretrig: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pretrig));

  a_r6_trig_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> busy);

  a_r6_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));

  a_r10_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((pretrig & ~$past(en_q)) == '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(err_we) |-> ((seq_err & $past(seq_err)) == $past(seq_err)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_we) |-> ((chan_flag & $past(chan_flag)) == $past(chan_flag)));
endmodule

bind pretrig_seq pretrig_seq_chk #(.NPT(NPT)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .conv_done(conv_done),
  .err_we(err_we), .flag_we(flag_we), .pretrig(pretrig), .trig(trig),
  .busy(busy), .chan_flag(chan_flag), .seq_err(seq_err)
);

// File: tb/test_pretrig_seq.sv
module test_pretrig_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic        dly_we = 1'b0;
  logic [2:0]  dly_idx = '0;
  logic [15:0] dly_wdata = '0;
  logic [15:0] cnt = '0;
  logic        cnt_tick = 1'b0;
  logic        start = 1'b0;
  logic        sw_start = 1'b0;
  logic        conv_done = 1'b0;
  logic        flag_we = 1'b0;
  logic [7:0]  flag_wdata = '0;
  logic        err_we = 1'b0;
  logic [7:0]  err_wdata = '0;
  logic [7:0]  pretrig, chan_flag, seq_err;
  logic        trig, busy;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  pretrig_seq i_pretrig_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dly_we(dly_we), .dly_idx(dly_idx), .dly_wdata(dly_wdata),
    .cnt(cnt), .cnt_tick(cnt_tick), .start(start), .sw_start(sw_start),
    .conv_done(conv_done), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .err_we(err_we), .err_wdata(err_wdata), .pretrig(pretrig), .trig(trig),
    .busy(busy), .chan_flag(chan_flag), .seq_err(seq_err)
  );

  // row: start, tick, done, cnt[15:0], exp pretrig[7:0], exp trig, exp busy
  localparam int NROW = 14;
  localparam logic [28:0] VEC [NROW] = '{
    {1'b1, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 1'b0},  // R3 start edge sampled
    {1'b0, 1'b0, 1'b0, 16'd0, 8'h01, 1'b1, 1'b1},  // R3 bypass shot, R6
    {1'b0, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 1'b1},  // R6 strobe is one cycle
    {1'b0, 1'b0, 1'b1, 16'd0, 8'h00, 1'b0, 1'b0},  // R6 done clears busy
    {1'b0, 1'b1, 1'b0, 16'd3, 8'h02, 1'b1, 1'b1},  // R4 timed, R10 pt4 silent
    {1'b0, 1'b1, 1'b0, 16'd4, 8'h00, 1'b0, 1'b1},  // R5 chained ignores delay
    {1'b0, 1'b0, 1'b1, 16'd0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 16'd6, 8'h04, 1'b1, 1'b1},  // R4 timed pt2
    {1'b0, 1'b0, 1'b1, 16'd0, 8'h08, 1'b1, 1'b1},  // R5 chain after pt2
    {1'b0, 1'b0, 1'b1, 16'd0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'd0, 8'h01, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b0, 16'd3, 8'h00, 1'b0, 1'b1},  // R7 rejected while busy
    {1'b0, 1'b0, 1'b1, 16'd0, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic s, logic t, logic d, logic [15:0] c);
    @(negedge clk);
    start = s; cnt_tick = t; conv_done = d; cnt = c;
    @(posedge clk);
    #5;
  endtask

  task automatic set_dly(logic [2:0] i, logic [15:0] v);
    @(negedge clk);
    dly_we = 1'b1; dly_idx = i; dly_wdata = v;
    @(negedge clk);
    dly_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1 pretrig", {8'h0, pretrig}, 16'h0);
    check("R1 trig/busy", {14'h0, trig, busy}, 16'h0);
    check("R1 flags", {chan_flag, seq_err}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: en=0x0F, bypass pt0, timed pt1..3, pt3 chained
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {8'h08, 8'h0E, 8'h0F};
    @(negedge clk);
    cfg_we = 1'b0;
    set_dly(3'd0, 16'd9);
    set_dly(3'd1, 16'd3);
    set_dly(3'd2, 16'd6);
    set_dly(3'd3, 16'd4);
    set_dly(3'd4, 16'd3);
    check("R1 idle after setup", {pretrig, 6'h0, trig, busy}, 16'h0);

    for (int r = 0; r < NROW; r++) begin
      step(VEC[r][28], VEC[r][27], VEC[r][26], VEC[r][25:10]);
      check($sformatf("R3-row%0d pretrig", r), {8'h0, pretrig}, {8'h0, VEC[r][9:2]});
      check($sformatf("R6-row%0d trig/busy", r), {14'h0, trig, busy}, {14'h0, VEC[r][1:0]});
    end
    step(1'b0, 1'b0, 1'b0, 16'd0);
    check("R7 error on pt1 only", {8'h0, seq_err}, 16'h0002);
    check("R9 flags pt1..3, R10 none on pt4", {8'h0, chan_flag}, 16'h000E);

    // R8: write-0 clear of error bit 1
    @(negedge clk);
    err_we = 1'b1; err_wdata = 8'hFD;
    @(posedge clk); #5;
    err_we = 1'b0;
    check("R8 error cleared", {8'h0, seq_err}, 16'h0000);

    // R9: write-0 clear of flag 3, writing 1 keeps the rest
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = 8'hF7;
    @(posedge clk); #5;
    flag_we = 1'b0;
    check("R9 flag cleared", {8'h0, chan_flag}, 16'h0006);

    // R7: two timed pre-triggers on the same delay, channel free
    set_dly(3'd2, 16'd3);
    @(negedge clk);
    sw_start = 1'b1;
    @(posedge clk); #5;
    @(negedge clk);
    sw_start = 1'b0;
    @(posedge clk); #5;
    check("R3 software start bypass", {8'h0, pretrig}, 16'h0001);
    step(1'b0, 1'b0, 1'b1, 16'd0);
    check("R6 busy cleared", {15'h0, busy}, 16'h0);
    step(1'b0, 1'b1, 1'b0, 16'd3);
    check("R7 lowest index wins", {8'h0, pretrig}, 16'h0002);
    check("R7 loser logged", {8'h0, seq_err}, 16'h0004);
    step(1'b0, 1'b0, 1'b1, 16'd0);
    step(1'b0, 1'b1, 1'b0, 16'd3);
    check("R4 once per start", {8'h0, pretrig}, 16'h0000);
    check("R4 no new error", {8'h0, seq_err}, 16'h0004);
    check("R10 pt4 flag stays clear", {8'h0, chan_flag}, 16'h0006);
    step(1'b0, 1'b0, 1'b0, 16'd0);

    // R10: disabled pre-triggers under bypass and start
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {8'h00, 8'h00, 8'h00};
    @(negedge clk);
    cfg_we = 1'b0;
    step(1'b1, 1'b0, 1'b0, 16'd0);
    step(1'b0, 1'b0, 1'b0, 16'd0);
    check("R10 disabled bypass silent", {8'h0, pretrig}, 16'h0000);
    check("R10 disabled no trig", {15'h0, trig}, 16'h0);

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule